// File: doc/BRIEF.md
# Enabled Counter with Remapped Output Code

This block is a small synchronous Moore machine. A 2-bit state register counts upward, one step per clock edge on which the count-enable input is high. When it passes 3 it wraps to 0. A registered decoder turns each count value into a fixed 3-bit code. The output therefore walks the sequence 1, 2, 3, 5 and repeats, rather than showing the raw count.

The output depends only on the stored state. A change on the enable input can only show at the output after the next rising clock edge. The raw state is also brought out, so the decoded code can be compared against it. Reset is synchronous and active high.

Top module: `seq_code_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, the state becomes 00 and the code becomes 001 after that edge, whatever the value of `en`.
- R2: At a rising edge with `rst` 0 and `en` 1, the state increases by one. From 11 it wraps to 00.
- R3: At a rising edge with `rst` 0 and `en` 0, the state and the code keep their values.
- R4: The code maps the state as follows: 00 gives 001, 01 gives 010, 10 gives 011, and 11 gives 101.
- R5: Between rising edges the code does not change, even when `en` toggles. No combinational path runs from `en` to `code_o`.
- R6: After every edge, `code_o` equals the R4 mapping of the `state_o` value shown in the same cycle. Over five enabled cycles after reset, the output reads 2, 3, 5, 1, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; 1 advances the state at the edge |
| code_o | output | 3 | Registered remapped code of the current state |
| state_o | output | 2 | Raw 2-bit count state |

## Verification
The counter is driven with long runs of enable high that pass the wrap point. These runs show that every state gets its own code and that 11 wraps to 00. Enable-low gaps placed in the middle of a count separate holding from advancing. A reset applied while enable is high shows that reset takes priority over counting. Toggling enable several times between two clock edges shows that the output has no combinational path from the input.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
    localparam int CNT_W = 2;
    localparam int OUT_W = 3;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [OUT_W-1:0] code_t;

    // fixed remapping of count value to output code
    function automatic code_t map_code(input cnt_t s);
        code_t c;
        case (s)
            2'd0:    c = 3'b001;
            2'd1:    c = 3'b010;
            2'd2:    c = 3'b011;
            default: c = 3'b101;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/cmap_counter.sv
module cmap_counter
    import cmap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    output cnt_t state_d_o,
    output cnt_t state_q_o
);
    typedef struct packed {
        cnt_t state;
    } cnt_regs_t;

    cnt_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = '0;
        end else if (en) begin
            regs_d.state = regs_q.state + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_d_o = regs_d.state;
    assign state_q_o = regs_q.state;

    // R1: reset clears the state
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (regs_q.state == '0));

    // R2: enabled step advances by one with wrap
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        en |=> (regs_q.state == cnt_t'($past(regs_q.state) + cnt_t'(1))));

    // R3: disabled step holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(regs_q.state));
endmodule

// File: rtl/cmap_decoder.sv
module cmap_decoder
    import cmap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cnt_t  state_d_i,
    input  cnt_t  state_q_i,
    output code_t code_q_o
);
    typedef struct packed {
        code_t code;
    } dec_regs_t;

    dec_regs_t regs_d, regs_q;

    // decode the upcoming state so the registered code lines up with it
    always_comb begin
        regs_d.code = map_code(state_d_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.code <= map_code('0);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign code_q_o = regs_q.code;

    // R1: reset yields code 001
    assert_reset_code_R1: assert property (@(posedge clk)
        rst |=> (regs_q.code == 3'b001));

    // R4 / R6: registered code tracks the counter's stored state
    assert_map_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (regs_q.code == map_code(state_q_i)));
endmodule

// File: rtl/seq_code_counter.sv
module seq_code_counter
    import cmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [2:0] code_o,
    output logic [1:0] state_o
);
    cnt_t  state_d;
    cnt_t  state_q;
    code_t code_q;

    cmap_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .state_d_o (state_d),
        .state_q_o (state_q)
    );

    cmap_decoder u_decoder (
        .clk       (clk),
        .rst       (rst),
        .state_d_i (state_d),
        .state_q_i (state_q),
        .code_q_o  (code_q)
    );

    assign code_o  = code_q;
    assign state_o = state_q;

    // R5: output moves only together with the state
    assert_code_stable_R5: assert property (@(posedge clk) disable iff (rst)
        $stable(state_o) |-> $stable(code_o));
endmodule

// File: tb/seq_code_counter_tb.sv
`timescale 1ns/1ps
module seq_code_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] code_o;
    logic [1:0] state_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        logic [1:0] st;
        logic [2:0] cd;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [1:0] model_st = 2'd0;

    always #2.5 clk = ~clk;

    seq_code_counter u_dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .code_o  (code_o),
        .state_o (state_o)
    );

    // R4 mapping as stated in the requirement
    function automatic logic [2:0] exp_code(input logic [1:0] s);
        case (s)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd3;
            default: return 3'd5;
        endcase
    endfunction

    task automatic step(input logic r, input logic e, input string tag);
        exp_t x;
        @(negedge clk);
        rst = r;
        en  = e;
        if (r)      model_st = 2'd0;
        else if (e) model_st = model_st + 2'd1;
        x.st  = model_st;
        x.cd  = exp_code(model_st);
        x.tag = tag;
        sb.push_back(x);
    endtask

    // R5: toggle enable between edges, code must not move
    task automatic glitch_check();
        logic [2:0] ref_cd;
        @(negedge clk);
        rst    = 1'b0;
        ref_cd = code_o;
        for (int i = 0; i < 4; i++) begin
            #0.4 en = ~en;
            checks++;
            if (code_o !== ref_cd) begin
                failures++;
                $display("FAIL R5 code moved between edges: actual=%0d expected=%0d", code_o, ref_cd);
            end
        end
        en = 1'b0;
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks++;
                if (state_o !== x.st || code_o !== x.cd) begin
                    failures++;
                    $display("FAIL %s state/code actual=%0d/%0d expected=%0d/%0d",
                             x.tag, state_o, code_o, x.st, x.cd);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state, also with enable high
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        // R3: hold right after reset
        step(1'b0, 1'b0, "R3");
        // R2/R4/R6: five enabled cycles, codes 2,3,5,1,2 (wrap)
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R6");
        // R3: disabled gap
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, "R3");
        // mixed pattern
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R2");
        // R1: reset mid-count with enable high
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R2");
        // R5: toggles between edges
        step(1'b0, 1'b0, "R3");
        glitch_check();
        step(1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, "R4");
        glitch_check();
        step(1'b0, 1'b1, "R6");
        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end
endmodule